// File: doc/BRIEF.md
# Fractional-N Modulus Sequencer

This block picks, once per feedback-divider cycle, the integer ratio the divider should use next. It does this so that the long-run average ratio equals an integer base plus a fraction numerator over a modulus. The chosen value is either the base or the base plus one. A first-order phase accumulator decides between the two. The accumulator grows by the numerator on every divider-cycle strobe. When the sum reaches the modulus, the accumulator wraps, and that cycle takes the larger ratio.

The decision is presented combinationally on `div_value`. It is derived from the current accumulator and the configuration, and it is the value the divider loads on its next strobe. The accumulator then advances on that strobe. The strobe is a plain pulse that cannot be stalled: there is no back-pressure, and the divider consumes one decision per pulse. A configuration whose numerator is not below the modulus is flagged and handled as a zero fraction. Software is expected to pulse the reload input after every configuration change.

Top module: `frac_mod_sequencer`

## Requirements
- R1: `div_value` always equals `int_part` or `int_part + 1`. It is `int_part + 1` exactly when the accumulator plus the effective fraction is greater than or equal to `modulus`.
- R2: On a strobe without reload, the accumulator takes accumulator plus effective fraction, minus `modulus` when the R1 condition holds.
- R3: In a cycle with neither strobe nor reload, the accumulator keeps its value, so `div_value` stays unchanged while the configuration is stable.
- R4: With `int_part` 900, `frac_num` 1 and `modulus` 5, each group of 5 consecutive strobes after a reload produces 900 four times and 901 once.
- R5: With a valid stable configuration, any window of exactly `modulus` consecutive strobes contains exactly `frac_num` cycles of `int_part + 1`.
- R6: With `frac_num` equal to 0, `div_value` equals `int_part` on every cycle.
- R7: `cfg_err` is 1 exactly when `frac_num >= modulus` (this includes `modulus` equal to 0). In that case the effective fraction is 0 and `div_value` equals `int_part`.
- R8: Reset (`rst_n` low, asynchronous) clears the accumulator to 0.
- R9: `cfg_reload` clears the accumulator to 0 at the next clock edge, and it takes priority over a simultaneous strobe.
- R10: `div_value` is one bit wider than `int_part`, so with `int_part` 65535 the larger ratio reads 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_reload | input | 1 | Clears the accumulator; pulse after a configuration change |
| step_strobe | input | 1 | One pulse per divider cycle; advances the accumulator |
| int_part | input | INT_W (16) | Integer base of the ratio |
| frac_num | input | FRAC_W (12) | Fraction numerator |
| modulus | input | FRAC_W (12) | Fraction denominator |
| div_value | output | INT_W+1 (17) | Ratio the divider uses for its next cycle |
| cfg_err | output | 1 | Numerator not below modulus; fraction treated as 0 |

## Verification
The bench builds the block with its default widths: a 16-bit integer base and 12-bit fraction fields. This keeps the full modulus range of 4095 within reach. A complete R5 window at that modulus fits in one run, and the base of 65535 exercises the widened output.

The reference model is a plain integer accumulator. It is compared with `div_value` and `cfg_err` on every clock. It covers:
- strobe gaps,
- reloads that collide with strobes,
- a reset in the middle of a run,
- the invalid configurations where the numerator equals the modulus and where the modulus is 0.

// File: rtl/fnms_pkg.sv
package fnms_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_ADD   = 2'd1,
    ACT_WRAP  = 2'd2,
    ACT_CLEAR = 2'd3
  } acc_act_e;
endpackage

// File: rtl/fnms_frac_guard.sv
// Validates the fraction against the modulus; an invalid pair yields zero.
module fnms_frac_guard #(
  parameter int FRAC_W = 12
) (
  input  logic [FRAC_W-1:0] frac_num,
  input  logic [FRAC_W-1:0] modulus,
  output logic [FRAC_W-1:0] frac_eff,
  output logic              bad_cfg
);
  always_comb begin
    bad_cfg  = (frac_num >= modulus);
    frac_eff = bad_cfg ? '0 : frac_num;
  end
endmodule

// File: rtl/fnms_carry_unit.sv
// Sums accumulator and fraction, detects the wrap and forms the wrapped value.
module fnms_carry_unit #(
  parameter int FRAC_W = 12
) (
  input  logic [FRAC_W-1:0] acc,
  input  logic [FRAC_W-1:0] frac_eff,
  input  logic [FRAC_W-1:0] modulus,
  output logic              carry,
  output logic [FRAC_W-1:0] acc_next
);
  localparam int SUM_W = FRAC_W + 1;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] wrapped;

  always_comb begin
    sum      = {1'b0, acc} + {1'b0, frac_eff};
    wrapped  = sum - {1'b0, modulus};
    carry    = (frac_eff != '0) && (sum >= {1'b0, modulus});
    acc_next = carry ? wrapped[FRAC_W-1:0] : sum[FRAC_W-1:0];
  end
endmodule

// File: rtl/fnms_phase_reg.sv
// Accumulator register driven by an action code.
module fnms_phase_reg
  import fnms_pkg::*;
#(
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_act_e          act,
  input  logic [FRAC_W-1:0] acc_next,
  output logic [FRAC_W-1:0] acc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      unique case (act)
        ACT_CLEAR: acc_q <= '0;
        ACT_ADD,
        ACT_WRAP:  acc_q <= acc_next;
        default:   acc_q <= acc_q;
      endcase
    end
  end
endmodule

// File: rtl/frac_mod_sequencer.sv
module frac_mod_sequencer
  import fnms_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_reload,
  input  logic              step_strobe,
  input  logic [INT_W-1:0]  int_part,
  input  logic [FRAC_W-1:0] frac_num,
  input  logic [FRAC_W-1:0] modulus,
  output logic [INT_W:0]    div_value,
  output logic              cfg_err
);
  localparam int OUT_W = INT_W + 1;

  logic [FRAC_W-1:0] frac_eff;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W-1:0] acc_next;
  logic              carry;
  acc_act_e          act;

  fnms_frac_guard #(.FRAC_W(FRAC_W)) i_guard (
    .frac_num (frac_num),
    .modulus  (modulus),
    .frac_eff (frac_eff),
    .bad_cfg  (cfg_err)
  );

  fnms_carry_unit #(.FRAC_W(FRAC_W)) i_carry (
    .acc      (acc_q),
    .frac_eff (frac_eff),
    .modulus  (modulus),
    .carry    (carry),
    .acc_next (acc_next)
  );

  always_comb begin
    if (cfg_reload)       act = ACT_CLEAR;
    else if (!step_strobe) act = ACT_HOLD;
    else if (carry)       act = ACT_WRAP;
    else                  act = ACT_ADD;
  end

  fnms_phase_reg #(.FRAC_W(FRAC_W)) i_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act),
    .acc_next (acc_next),
    .acc_q    (acc_q)
  );

  assign div_value = OUT_W'(int_part) + OUT_W'(carry);
endmodule

// File: rtl/frac_mod_sequencer_chk.sv
module frac_mod_sequencer_chk #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_reload,
  input logic              step_strobe,
  input logic [INT_W-1:0]  int_part,
  input logic [FRAC_W-1:0] frac_num,
  input logic [FRAC_W-1:0] modulus,
  input logic [INT_W:0]    div_value,
  input logic              cfg_err,
  input logic [FRAC_W-1:0] acc
);
  logic [INT_W:0] base_w;
  assign base_w = {1'b0, int_part};

  // R1: ratio is base or base plus one
  assert_div_span_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (div_value == base_w) || (div_value == base_w + 1'b1));

  // R2: a wrapping strobe subtracts the modulus
  assert_wrap_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_strobe && !cfg_reload && !cfg_err && div_value != base_w)
    |=> ({1'b0, acc} == {1'b0, $past(acc)} + {1'b0, $past(frac_num)} - {1'b0, $past(modulus)}));

  // R3: no strobe, no reload keeps the accumulator
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_strobe && !cfg_reload) |=> $stable(acc));

  // R6: zero fraction never adds one
  assert_zero_frac_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_num == '0) |-> (div_value == base_w));

  // R7: invalid configuration flagged and treated as zero
  assert_err_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_num >= modulus) |-> (cfg_err && div_value == base_w));

  // R9: reload clears the accumulator
  assert_reload_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reload |=> (acc == '0));
endmodule

bind frac_mod_sequencer frac_mod_sequencer_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_reload  (cfg_reload),
  .step_strobe (step_strobe),
  .int_part    (int_part),
  .frac_num    (frac_num),
  .modulus     (modulus),
  .div_value   (div_value),
  .cfg_err     (cfg_err),
  .acc         (acc_q)
);

// File: tb/test_frac_mod_sequencer.sv
`timescale 1ns/1ps
module test_frac_mod_sequencer;
  localparam int INT_W  = 16;
  localparam int FRAC_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_reload = 1'b0;
  logic              step_strobe = 1'b0;
  logic [INT_W-1:0]  int_part = '0;
  logic [FRAC_W-1:0] frac_num = '0;
  logic [FRAC_W-1:0] modulus = '0;
  logic [INT_W:0]    div_value;
  logic              cfg_err;

  int checks = 0;
  int errors = 0;
  int m_acc = 0;
  int plus_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  frac_mod_sequencer #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_frac_mod_sequencer (
    .clk(clk), .rst_n(rst_n), .cfg_reload(cfg_reload), .step_strobe(step_strobe),
    .int_part(int_part), .frac_num(frac_num), .modulus(modulus),
    .div_value(div_value), .cfg_err(cfg_err)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit m_err();
    return int'(frac_num) >= int'(modulus);
  endfunction

  function automatic bit m_carry();
    int fe = m_err() ? 0 : int'(frac_num);
    return (fe != 0) && (m_acc + fe >= int'(modulus));
  endfunction

  // one cycle: drive, compare with model, clock, advance model
  task automatic step(input bit stb, input bit rld);
    int fe;
    step_strobe = stb;
    cfg_reload  = rld;
    #0.5;
    check("R1 R2 div_value", div_value, int'(int_part) + m_carry());
    check("R7 cfg_err", cfg_err, m_err());
    if (stb && !rld && m_carry()) plus_cnt++;
    fe = m_err() ? 0 : int'(frac_num);
    @(posedge clk);
    if (rld) m_acc = 0;
    else if (stb) m_acc = m_carry() ? m_acc + fe - int'(modulus) : m_acc + fe;
    @(negedge clk);
  endtask

  task automatic configure(input int ip, input int fn, input int md);
    int_part = INT_W'(ip);
    frac_num = FRAC_W'(fn);
    modulus  = FRAC_W'(md);
    step(1'b0, 1'b1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int_part = 16'd900; frac_num = 12'd1; modulus = 12'd5;
    repeat (3) @(negedge clk);
    // R8: reset state, accumulator at zero
    check("R8 reset div_value", div_value, 900);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: 900 + 1/5
    configure(900, 1, 5);
    plus_cnt = 0;
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
    check("R4 plus-one count over 20 strobes", plus_cnt, 4);

    // R3: gaps between strobes
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
    end

    // R5: windows with several fractions
    configure(1234, 7, 12);
    plus_cnt = 0;
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0);
    check("R5 window 7/12", plus_cnt, 7);
    plus_cnt = 0;
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0);
    check("R5 second window 7/12", plus_cnt, 7);

    configure(40000, 4094, 4095);
    plus_cnt = 0;
    for (int i = 0; i < 4095; i++) step(1'b1, 1'b0);
    check("R5 window 4094/4095", plus_cnt, 4094);

    configure(77, 1000, 4095);
    plus_cnt = 0;
    for (int i = 0; i < 4095; i++) step(1'b1, 1'b0);
    check("R5 window 1000/4095", plus_cnt, 1000);

    // R6: zero fraction
    configure(500, 0, 9);
    plus_cnt = 0;
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0);
    check("R6 zero fraction plus count", plus_cnt, 0);

    // R7: numerator equal to modulus, and zero modulus
    configure(321, 5, 5);
    check("R7 err flag frac==mod", cfg_err, 1);
    plus_cnt = 0;
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0);
    check("R7 no plus-one when invalid", plus_cnt, 0);
    configure(321, 0, 0);
    check("R7 err flag zero modulus", cfg_err, 1);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);

    // R9: reload wins over strobe
    configure(900, 3, 4);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    plus_cnt = 0;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    check("R9 window after reload 3/4", plus_cnt, 3);

    // R10: widened output at the top of the base range
    configure(65535, 3, 4);
    step(1'b1, 1'b0);
    check("R10 first carry value", div_value, 65536);

    // R8: reset in the middle of a run
    configure(900, 2, 5);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    rst_n = 1'b0;
    #0.5;
    m_acc = 0;
    check("R8 mid-run reset div_value", div_value, 900);
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule